// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block is the processor-side bus agent that turns a pending maskable interrupt into the vector number the core needs to dispatch it. The interrupt request is a level. The sequencer looks at it only in a clock where the core signals an instruction-retirement boundary. When it accepts a request while another bus cycle is still in flight, it waits for that cycle to complete before it takes the bus.

It then runs two single-transfer read cycles as one locked pair. Both cycles carry the interrupt-acknowledge cycle type (data/code, memory/io and write/read indications all low) and a zero address. The first read is a dummy, and whatever comes back on it is thrown away. The second read enables only the lowest byte lane and delivers the vector on the low data bits. A programmable number of idle clocks, at least one, separates the two reads, and the lock stays asserted through that gap.

After the second ready, the lock drops. The captured vector is then offered to the core on a valid/ready handshake, and further requests are ignored until the core accepts it.

Top module: `intack_seq`

## Requirements
- R1: A synchronous active-high reset, from any state, leaves lock_n=1, ads_n=1, bus_own=0, ben_n=8'hFF and vec_valid=0 in the clock that follows it.
- R2: A request is accepted only in a clock where both intr_req and retire_stb are 1. Neither signal alone starts a bus cycle.
- R3: If bus_busy is 1 when a request is accepted, ads_n stays 1 while bus_busy stays 1. The first ads_n pulse appears in the clock after the first edge at which bus_busy is sampled 0. With bus_busy at 0, that pulse appears in the clock right after the accepting edge.
- R4: The first acknowledge cycle drives ben_n=8'hEF, addr=0, cyc_dc=cyc_mio=cyc_wr=0 and lock_n=0.
- R5: A cycle ends only at an edge where brdy_n is sampled 0. Until then, ben_n, lock_n and the cycle outputs hold their values, and ads_n stays 1.
- R6: After the first cycle's ready, ads_n stays 1 for exactly GAP_CLKS clocks (GAP_CLKS >= 1) while lock_n stays 0. The second ads_n pulse follows directly after.
- R7: The second acknowledge cycle drives ben_n=8'hFE, so only byte lane 0 is enabled, together with addr=0, all cycle-type bits 0 and lock_n=0.
- R8: rd_data sampled at the first cycle's ready is discarded. vec_data equals rd_data[VEC_W-1:0] as sampled at the second cycle's ready.
- R9: In the clock after the second ready, lock_n=1, bus_own=0, ben_n=8'hFF and vec_valid=1.
- R10: While vec_valid=1 and vec_ready=0, vec_valid and vec_data hold, and intr_req with retire_stb starts no bus cycle. vec_valid falls in the clock after an edge at which vec_ready is 1.
- R11: ads_n is 0 for exactly one clock at the start of each acknowledge cycle, and never on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intr_req | input | 1 | Level-sensitive maskable interrupt request |
| retire_stb | input | 1 | Core strobe marking an instruction-retirement boundary |
| bus_busy | input | 1 | High while a previously started bus cycle is outstanding |
| brdy_n | input | 1 | Active-low ready that ends the current cycle |
| rd_data | input | VEC_W | Low lanes of the read data bus |
| ads_n | output | 1 | Active-low address strobe, one clock per cycle |
| lock_n | output | 1 | Active-low bus lock held across the read pair |
| bus_own | output | 1 | High while the sequencer owns the bus |
| ben_n | output | 8 | Active-low byte enables |
| addr | output | ADDR_W | Quadword address, zero during acknowledge |
| cyc_dc | output | 1 | Data/code cycle indication, 0 for acknowledge |
| cyc_mio | output | 1 | Memory/io cycle indication, 0 for acknowledge |
| cyc_wr | output | 1 | Write/read indication, 0 for acknowledge |
| vec_valid | output | 1 | Captured vector is available to the core |
| vec_ready | input | 1 | Core accepts the vector |
| vec_data | output | VEC_W | Captured interrupt vector |

## Verification
The bench builds the sequencer with GAP_CLKS=3 rather than the default of one, so the idle-gap counter has to count down through several values. A gap that is off by one clock in either direction then shows up at ads_n. VEC_W stays at 8 and ADDR_W at 29, which keeps the vector width at the lane the second cycle enables. Table rows vary the outstanding-cycle length and the ready wait states on each read independently, so that both drain timing and the hold-while-waiting rule are reached with zero and non-zero waits.

// File: rtl/intack_pkg.sv
package intack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_ADS_A,
        ST_WAIT_A,
        ST_GAP,
        ST_ADS_B,
        ST_WAIT_B,
        ST_HAND
    } ack_state_e;

    localparam int unsigned LANES = 8;
    localparam logic [LANES-1:0] BE_DUMMY_N  = 8'hEF;
    localparam logic [LANES-1:0] BE_VECTOR_N = 8'hFE;
    localparam logic [LANES-1:0] BE_NONE_N   = 8'hFF;

    typedef struct packed {
        logic             ads_n;
        logic             lock_n;
        logic             own;
        logic [LANES-1:0] ben_n;
    } bus_drive_t;

    function automatic bus_drive_t drive_for(ack_state_e s);
        bus_drive_t d;
        d.ads_n  = 1'b1;
        d.lock_n = 1'b1;
        d.own    = 1'b0;
        d.ben_n  = BE_NONE_N;
        unique case (s)
            ST_ADS_A:  begin d.ads_n = 1'b0; d.lock_n = 1'b0; d.own = 1'b1; d.ben_n = BE_DUMMY_N;  end
            ST_WAIT_A: begin                 d.lock_n = 1'b0; d.own = 1'b1; d.ben_n = BE_DUMMY_N;  end
            ST_GAP:    begin                 d.lock_n = 1'b0; d.own = 1'b1;                        end
            ST_ADS_B:  begin d.ads_n = 1'b0; d.lock_n = 1'b0; d.own = 1'b1; d.ben_n = BE_VECTOR_N; end
            ST_WAIT_B: begin                 d.lock_n = 1'b0; d.own = 1'b1; d.ben_n = BE_VECTOR_N; end
            default:   begin end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/intack_fsm.sv
module intack_fsm
    import intack_pkg::*;
#(
    parameter int unsigned GAP_CLKS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       intr_req,
    input  logic       retire_stb,
    input  logic       bus_busy,
    input  logic       brdy_n,
    input  logic       hand_done,
    output ack_state_e st,
    output logic       capture
);

    localparam int unsigned GW = (GAP_CLKS < 2) ? 1 : $clog2(GAP_CLKS);
    localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CLKS - 1);

    ack_state_e      st_nx;
    logic [GW-1:0]   gap_cnt;
    logic            accept;

    assign accept  = intr_req && retire_stb;
    assign capture = (st == ST_WAIT_B) && !brdy_n;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (accept) st_nx = bus_busy ? ST_DRAIN : ST_ADS_A;
            ST_DRAIN:  if (!bus_busy) st_nx = ST_ADS_A;
            ST_ADS_A:  st_nx = ST_WAIT_A;
            ST_WAIT_A: if (!brdy_n) st_nx = ST_GAP;
            ST_GAP:    if (gap_cnt == '0) st_nx = ST_ADS_B;
            ST_ADS_B:  st_nx = ST_WAIT_B;
            ST_WAIT_B: if (!brdy_n) st_nx = ST_HAND;
            ST_HAND:   if (hand_done) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            gap_cnt <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_WAIT_A)
                gap_cnt <= GAP_LOAD;
            else if (st == ST_GAP && gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;
        end
    end

    p_retire_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !retire_stb) |=> (st == ST_IDLE))
        else $error("R2: left idle without retirement strobe");

    p_drain_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN && bus_busy) |=> (st == ST_DRAIN))
        else $error("R3: drain left while bus busy");

    p_wait_ready_r5: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_WAIT_A || st == ST_WAIT_B) && brdy_n) |=> $stable(st))
        else $error("R5: cycle ended without ready");

    p_gap_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_A && !brdy_n) |=> (st == ST_GAP))
        else $error("R6: first ready did not open the gap");

    p_hand_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HAND && !hand_done) |=> (st == ST_HAND))
        else $error("R10: handshake state left early");

endmodule

// File: rtl/intack_vec.sv
module intack_vec #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [VEC_W-1:0] rd_data,
    input  logic             vec_ready,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_data  <= '0;
        end else if (capture) begin
            vec_valid <= 1'b1;
            vec_data  <= rd_data;
        end else if (vec_valid && vec_ready) begin
            vec_valid <= 1'b0;
        end
    end

    p_vec_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)))
        else $error("R10: vector dropped before acceptance");

    p_vec_take_r8: assert property (@(posedge clk) disable iff (rst)
        capture |=> (vec_valid && vec_data == $past(rd_data)))
        else $error("R8: vector not taken from second read");

endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
#(
    parameter int unsigned ADDR_W   = 29,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned GAP_CLKS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              intr_req,
    input  logic              retire_stb,
    input  logic              bus_busy,
    input  logic              brdy_n,
    input  logic [VEC_W-1:0]  rd_data,
    output logic              ads_n,
    output logic              lock_n,
    output logic              bus_own,
    output logic [LANES-1:0]  ben_n,
    output logic [ADDR_W-1:0] addr,
    output logic              cyc_dc,
    output logic              cyc_mio,
    output logic              cyc_wr,
    output logic              vec_valid,
    input  logic              vec_ready,
    output logic [VEC_W-1:0]  vec_data
);

    ack_state_e st;
    logic       capture;
    bus_drive_t drv;

    intack_fsm #(.GAP_CLKS(GAP_CLKS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .intr_req   (intr_req),
        .retire_stb (retire_stb),
        .bus_busy   (bus_busy),
        .brdy_n     (brdy_n),
        .hand_done  (vec_valid && vec_ready),
        .st         (st),
        .capture    (capture)
    );

    intack_vec #(.VEC_W(VEC_W)) u_vec (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .rd_data   (rd_data),
        .vec_ready (vec_ready),
        .vec_valid (vec_valid),
        .vec_data  (vec_data)
    );

    assign drv     = drive_for(st);
    assign ads_n   = drv.ads_n;
    assign lock_n  = drv.lock_n;
    assign bus_own = drv.own;
    assign ben_n   = drv.ben_n;
    assign addr    = '0;
    assign cyc_dc  = 1'b0;
    assign cyc_mio = 1'b0;
    assign cyc_wr  = 1'b0;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (ads_n && lock_n && !bus_own && !vec_valid))
        else $error("R1: reset state wrong");

    p_ads_locked_r4: assert property (@(posedge clk) disable iff (rst)
        !ads_n |-> (!lock_n && bus_own && ben_n != BE_NONE_N))
        else $error("R4: strobe without lock and enables");

    p_lock_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_valid) |-> (lock_n && !bus_own))
        else $error("R9: lock still held with vector");

    p_ads_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> ads_n)
        else $error("R11: strobe longer than one clock");

    p_no_ads_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && !bus_own) |=> ads_n)
        else $error("R3: strobe while other cycle outstanding");

endmodule

// File: tb/sim_intack_seq.sv
module sim_intack_seq;

    localparam int unsigned ADDR_W   = 29;
    localparam int unsigned VEC_W    = 8;
    localparam int unsigned GAP_CLKS = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic intr_req = 1'b0, retire_stb = 1'b0, bus_busy = 1'b0, brdy_n = 1'b1;
    logic [VEC_W-1:0] rd_data = '0;
    logic vec_ready = 1'b0;
    logic ads_n, lock_n, bus_own, cyc_dc, cyc_mio, cyc_wr, vec_valid;
    logic [7:0] ben_n;
    logic [ADDR_W-1:0] addr;
    logic [VEC_W-1:0] vec_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    intack_seq #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .GAP_CLKS(GAP_CLKS)) u0 (
        .clk(clk), .rst(rst), .intr_req(intr_req), .retire_stb(retire_stb),
        .bus_busy(bus_busy), .brdy_n(brdy_n), .rd_data(rd_data),
        .ads_n(ads_n), .lock_n(lock_n), .bus_own(bus_own), .ben_n(ben_n),
        .addr(addr), .cyc_dc(cyc_dc), .cyc_mio(cyc_mio), .cyc_wr(cyc_wr),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data)
    );

    typedef struct packed {
        logic [3:0] nbusy;
        logic [3:0] w1;
        logic [3:0] w2;
        logic [7:0] d1;
        logic [7:0] d2;
    } row_t;

    localparam row_t TABLE [5] = '{
        '{4'd0, 4'd0, 4'd0, 8'h11, 8'h20},
        '{4'd2, 4'd0, 4'd1, 8'hA5, 8'h08},
        '{4'd0, 4'd3, 4'd0, 8'h5A, 8'hFF},
        '{4'd1, 4'd2, 4'd4, 8'h00, 8'h71},
        '{4'd5, 4'd1, 4'd2, 8'hC3, 8'h3C}
    };

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic check_cycle(input logic [7:0] be, input logic strobe, input string req);
        @(negedge clk);
        chk(ads_n == !strobe, req, ads_n, !strobe);
        chk(ben_n == be, req, ben_n, be);
        chk(lock_n == 1'b0, req, lock_n, 0);
        chk(addr == '0 && !cyc_dc && !cyc_mio && !cyc_wr, req, {addr, cyc_dc, cyc_mio, cyc_wr}, 0);
    endtask

    task automatic run_ack(input row_t r);
        step; intr_req = 1'b1; retire_stb = 1'b1; bus_busy = (r.nbusy != 0);
        step; retire_stb = 1'b0;
        for (int i = 0; i < int'(r.nbusy); i++) begin
            @(negedge clk);
            chk(ads_n == 1'b1, "R3", ads_n, 1);
            if (i == int'(r.nbusy) - 1) bus_busy = 1'b0;
            step;
        end
        check_cycle(8'hEF, 1'b1, "R4");
        step;
        for (int j = 0; j < int'(r.w1); j++) begin
            check_cycle(8'hEF, 1'b0, "R5");
            step;
        end
        brdy_n = 1'b0; rd_data = r.d1;
        check_cycle(8'hEF, 1'b0, "R5");
        step; brdy_n = 1'b1; rd_data = 8'h99;
        for (int g = 0; g < int'(GAP_CLKS); g++) begin
            @(negedge clk);
            chk(ads_n == 1'b1 && lock_n == 1'b0, "R6", {ads_n, lock_n}, 2'b10);
            step;
        end
        check_cycle(8'hFE, 1'b1, "R7");
        step;
        for (int j = 0; j < int'(r.w2); j++) begin
            check_cycle(8'hFE, 1'b0, "R5");
            step;
        end
        brdy_n = 1'b0; rd_data = r.d2;
        check_cycle(8'hFE, 1'b0, "R7");
        step; brdy_n = 1'b1; rd_data = 8'h66;
        @(negedge clk);
        chk(lock_n && !bus_own && ben_n == 8'hFF && vec_valid, "R9",
            {lock_n, bus_own, ben_n, vec_valid}, {1'b1, 1'b0, 8'hFF, 1'b1});
        chk(vec_data == r.d2, "R8", vec_data, r.d2);
        retire_stb = 1'b1;
        step; retire_stb = 1'b0;
        @(negedge clk);
        chk(vec_valid && ads_n && !bus_own && vec_data == r.d2, "R10",
            {vec_valid, ads_n, bus_own, vec_data}, {1'b1, 1'b1, 1'b0, r.d2});
        vec_ready = 1'b1;
        step; vec_ready = 1'b0; intr_req = 1'b0;
        @(negedge clk);
        chk(!vec_valid && ads_n, "R10", {vec_valid, ads_n}, 2'b01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step; step; rst = 1'b0;
        @(negedge clk);
        chk(ads_n && lock_n && !bus_own && ben_n == 8'hFF && !vec_valid, "R1",
            {ads_n, lock_n, bus_own, ben_n, vec_valid}, {1'b1, 1'b1, 1'b0, 8'hFF, 1'b0});

        foreach (TABLE[k]) run_ack(TABLE[k]);

        // R2: request without strobe, and strobe without request
        step; intr_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(ads_n && !bus_own, "R2", {ads_n, bus_own}, 2'b10);
            step;
        end
        intr_req = 1'b0; retire_stb = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(ads_n && !bus_own, "R2", {ads_n, bus_own}, 2'b10);
            step;
        end
        retire_stb = 1'b0;

        // R11: one-clock strobe observed over a full ack
        intr_req = 1'b1; retire_stb = 1'b1;
        step; retire_stb = 1'b0;
        @(negedge clk);
        chk(ads_n == 1'b0, "R11", ads_n, 0);
        step; brdy_n = 1'b0;
        @(negedge clk);
        chk(ads_n == 1'b1, "R11", ads_n, 1);

        // R1: reset in the middle of the locked pair
        rst = 1'b1;
        step; rst = 1'b0; brdy_n = 1'b1; intr_req = 1'b0;
        @(negedge clk);
        chk(ads_n && lock_n && !bus_own && ben_n == 8'hFF && !vec_valid, "R1",
            {ads_n, lock_n, bus_own, ben_n, vec_valid}, {1'b1, 1'b1, 1'b0, 8'hFF, 1'b0});
        step;
        @(negedge clk);
        chk(ads_n && !bus_own, "R1", {ads_n, bus_own}, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule